// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block gathers up to 32 interrupt request lines into one processor interrupt. Each line has a sense type fixed at build time by a parameter mask: level or rising edge. Each line records its request in a status bit. A pending word is the status ANDed with a per-source enable mask. The processor interrupt output goes high when anything is pending and both master-enable bits are set.

Software talks to the block over a simple word-addressed register port. A write is a single-cycle strobe, and read data is combinational from the selected word. Software changes enables in three ways: a full overwrite, write-one-to-set and write-one-to-clear. It retires a serviced request by writing ones to the acknowledge word. A vector word reports the number of the lowest-numbered pending source, so the handler needs no bit scan.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the status, pending, enable and master words read 0. The vector word reads 0xFFFFFFFF and `irq_out` is low.
- R2: A level-type source (default: lines 0..15, EDGE_MASK bit 0) sets its status bit at the first rising clock edge where its input is high. The bit stays set until it is acknowledged.
- R3: An edge-type source (default: lines 16..31, EDGE_MASK bit 1) sets its status bit only on a 0-to-1 input transition. A line held high after its acknowledge does not set the bit again.
- R4: A write to word 3 (acknowledge) clears every status bit whose data bit is 1. When a capture and an acknowledge reach the same bit on the same edge, the acknowledge wins, so a level line that is still high sets its bit again one clock later. Writing 0xFFFFFFFF clears all status bits.
- R5: A write to word 4 sets every enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R6: A write to word 5 clears every enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R7: A write to word 2 replaces the whole enable mask, so writing 0 disables every source. Word 2 reads back the mask.
- R8: Word 1 reads the status ANDed with the enable mask.
- R9: Word 6 reads the index of the lowest-numbered pending bit, zero-extended. It reads 0xFFFFFFFF when nothing is pending.
- R10: Word 7 holds two master-enable bits in data bits 1:0. `irq_out` is high exactly when both bits are 1 and at least one pending bit is 1.
- R11: Writes to words 0, 1 and 6 change nothing. Words 3, 4 and 5 read as 0. Word 0 reads the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word index of the register |
| bus_wen | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word |
| irq_in | input | 32 | Interrupt request lines |
| irq_out | output | 1 | Processor interrupt |

## Verification
The bench acknowledges a level line while it is still high. It expects the bit to read clear right after the write and set again one clock later. A design that let capture beat the acknowledge would never show the cleared state. A design that latched the level only once would not show the bit coming back. The bench holds an edge line high across an acknowledge and expects the status to stay clear, which exposes any design that treats edge lines as level. It also checks the vector with several pending sources, including a higher-numbered one enabled first, and with nothing pending. It gates the output with each master-bit combination, which catches designs that use only one master bit or ignore the enable mask.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC       = 32;
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 3;
    localparam int MASTER_W      = 2;
    localparam logic [NUM_SRC-1:0] DEF_EDGE_MASK = 32'hFFFF_0000;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENAB   = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_SETEN  = 3'd4,
        SEL_CLREN  = 3'd5,
        SEL_VEC    = 3'd6,
        SEL_MASTER = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic enab;
        logic ack;
        logic set_en;
        logic clr_en;
        logic master;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic wen,
                                                input logic [ADDR_W-1:0] addr);
        wr_strobe_t s;
        s.enab   = wen && (addr == SEL_ENAB);
        s.ack    = wen && (addr == SEL_ACK);
        s.set_en = wen && (addr == SEL_SETEN);
        s.clr_en = wen && (addr == SEL_CLREN);
        s.master = wen && (addr == SEL_MASTER);
        return s;
    endfunction

    // mask of all bit positions strictly below idx
    function automatic logic [NUM_SRC-1:0] below_mask(input int unsigned idx);
        logic [NUM_SRC-1:0] m;
        for (int b = 0; b < NUM_SRC; b++) m[b] = (b < idx);
        return m;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int                 N_SRC     = 32,
    parameter logic [N_SRC-1:0]   EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             ack_wr,
    input  logic [N_SRC-1:0] ack_bits,
    output logic [N_SRC-1:0] status
);

    logic [N_SRC-1:0] line_d;
    logic [N_SRC-1:0] hit;
    logic [N_SRC-1:0] clr;

    assign clr = ack_wr ? ack_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) line_d <= '0;
        else     line_d <= irq_in;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_line
        if (EDGE_MASK[g]) begin : g_edge
            assign hit[g] = irq_in[g] & ~line_d[g];

            // R3
            edge_only_rise_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(status[g]) |-> $past(irq_in[g] && !line_d[g]));
        end else begin : g_level
            assign hit[g] = irq_in[g];

            // R2
            level_capture_chk: assert property (@(posedge clk) disable iff (rst)
                (irq_in[g] && !clr[g]) |=> status[g]);
        end

        always_ff @(posedge clk) begin
            if (rst)         status[g] <= 1'b0;
            else if (clr[g]) status[g] <= 1'b0;
            else if (hit[g]) status[g] <= 1'b1;
        end
    end

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ack_wr |=> ((status & $past(ack_bits)) == '0));

endmodule

// File: rtl/irqc_enable.sv
module irqc_enable
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       wr,
    input  logic [N_SRC-1:0] wbits,
    output logic [N_SRC-1:0] enable
);

    always_ff @(posedge clk) begin
        if (rst)             enable <= '0;
        else if (wr.enab)    enable <= wbits;
        else if (wr.set_en)  enable <= enable | wbits;
        else if (wr.clr_en)  enable <= enable & ~wbits;
    end

    // R5
    set_en_chk: assert property (@(posedge clk) disable iff (rst)
        wr.set_en |=> ((enable & $past(wbits)) == $past(wbits)));

    // R5
    set_en_keep_chk: assert property (@(posedge clk) disable iff (rst)
        wr.set_en |=> ((enable & ~$past(wbits)) == ($past(enable) & ~$past(wbits))));

    // R6
    clr_en_chk: assert property (@(posedge clk) disable iff (rst)
        wr.clr_en |=> ((enable & $past(wbits)) == '0));

    // R7
    enab_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr.enab |=> (enable == $past(wbits)));

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int N_SRC = 32,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int                 N_SRC     = irqc_pkg::NUM_SRC,
    parameter logic [N_SRC-1:0]   EDGE_MASK = irqc_pkg::DEF_EDGE_MASK,
    localparam int                IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  irq_in,
    output logic              irq_out
);

    wr_strobe_t           wr;
    logic [N_SRC-1:0]     wbits;
    logic [N_SRC-1:0]     status;
    logic [N_SRC-1:0]     enable;
    logic [N_SRC-1:0]     pending;
    logic [MASTER_W-1:0]  master_q;
    logic                 any_pend;
    logic [IDX_W-1:0]     vec_idx;

    assign wr      = decode_write(bus_wen, bus_addr);
    assign wbits   = bus_wdata[N_SRC-1:0];
    assign pending = status & enable;

    irqc_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .ack_wr   (wr.ack),
        .ack_bits (wbits),
        .status   (status)
    );

    irqc_enable #(.N_SRC(N_SRC)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .wbits  (wbits),
        .enable (enable)
    );

    irqc_prio_enc #(.N_SRC(N_SRC)) u_prio (
        .req (pending),
        .any (any_pend),
        .idx (vec_idx)
    );

    always_ff @(posedge clk) begin
        if (rst)            master_q <= '0;
        else if (wr.master) master_q <= bus_wdata[MASTER_W-1:0];
    end

    assign irq_out = (&master_q) & any_pend;

    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr))
            SEL_STATUS: bus_rdata[N_SRC-1:0] = status;
            SEL_PEND:   bus_rdata[N_SRC-1:0] = pending;
            SEL_ENAB:   bus_rdata[N_SRC-1:0] = enable;
            SEL_VEC:    bus_rdata = any_pend ? DATA_W'(vec_idx) : '1;
            SEL_MASTER: bus_rdata[MASTER_W-1:0] = master_q;
            default:    bus_rdata = '0;
        endcase
    end

    // R9
    vec_is_pending_chk: assert property (@(posedge clk) disable iff (rst)
        any_pend |-> pending[vec_idx]);

    // R9
    vec_is_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        any_pend |-> ((pending & below_mask(32'(vec_idx))) == '0));

    // R10
    out_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
        (master_q != '1) |-> !irq_out);

    // R10
    out_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((status & enable) != '0));

endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  bus_addr;
    logic        bus_wen;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    localparam logic [2:0] W_STATUS = 3'd0, W_PEND = 3'd1, W_ENAB = 3'd2,
                           W_ACK = 3'd3, W_SET = 3'd4, W_CLR = 3'd5,
                           W_VEC = 3'd6, W_MASTER = 3'd7;

    always #5 clk = ~clk;

    vec_irq_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .irq_out   (irq_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0; irq_in = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        rd_check("R1 status", W_STATUS, 32'h0);
        rd_check("R1 pending", W_PEND, 32'h0);
        rd_check("R1 enable", W_ENAB, 32'h0);
        rd_check("R1 master", W_MASTER, 32'h0);
        rd_check("R1 vector", W_VEC, 32'hFFFF_FFFF);
        check("R1 irq_out", {31'd0, irq_out}, 32'h0);
    endtask

    task automatic t_enable;
        wr_reg(W_ENAB, 32'h0000_00F0);
        rd_check("R7 overwrite", W_ENAB, 32'h0000_00F0);
        wr_reg(W_SET, 32'h0000_0F00);
        rd_check("R5 set keeps others", W_ENAB, 32'h0000_0FF0);
        wr_reg(W_CLR, 32'h0000_00A0);
        rd_check("R6 clear keeps others", W_ENAB, 32'h0000_0F50);
        wr_reg(W_ENAB, 32'h0);
        rd_check("R7 write zero disables all", W_ENAB, 32'h0);
        rd_check("R11 set word reads zero", W_SET, 32'h0);
    endtask

    task automatic t_level;
        @(negedge clk); irq_in[3] = 1'b1;
        tick(1);
        rd_check("R2 level capture", W_STATUS, 32'h0000_0008);
        tick(3);
        rd_check("R2 level holds", W_STATUS, 32'h0000_0008);
        wr_reg(W_ACK, 32'h0000_0008);
        rd_check("R4 ack wins same edge", W_STATUS, 32'h0);
        tick(1);
        rd_check("R4 level re-sets next clock", W_STATUS, 32'h0000_0008);
        irq_in[3] = 1'b0;
        tick(2);
        rd_check("R2 stays set until ack", W_STATUS, 32'h0000_0008);
        wr_reg(W_ACK, 32'h0000_0008);
        tick(1);
        rd_check("R4 ack clears dropped level", W_STATUS, 32'h0);
    endtask

    task automatic t_edge;
        @(negedge clk); irq_in[20] = 1'b1;
        tick(1);
        rd_check("R3 edge capture", W_STATUS, 32'h0010_0000);
        wr_reg(W_ACK, 32'h0010_0000);
        tick(3);
        rd_check("R3 held edge line no re-set", W_STATUS, 32'h0);
        irq_in[20] = 1'b0;
        tick(1);
        irq_in[20] = 1'b1;
        tick(1);
        rd_check("R3 new rise captured", W_STATUS, 32'h0010_0000);
        irq_in[20] = 1'b0;
        wr_reg(W_ACK, 32'h0010_0000);
    endtask

    task automatic t_pending_vector;
        @(negedge clk);
        irq_in[5] = 1'b1; irq_in[9] = 1'b1; irq_in[12] = 1'b1;
        tick(1);
        rd_check("R8 nothing enabled", W_PEND, 32'h0);
        rd_check("R9 none pending", W_VEC, 32'hFFFF_FFFF);
        wr_reg(W_SET, 32'h0000_1200);
        rd_check("R8 pending masked", W_PEND, 32'h0000_1200);
        rd_check("R9 lowest of 9,12", W_VEC, 32'd9);
        wr_reg(W_SET, 32'h0000_0020);
        rd_check("R9 lowest of 5,9,12", W_VEC, 32'd5);
        check("R10 master off", {31'd0, irq_out}, 32'h0);
        wr_reg(W_MASTER, 32'h1);
        check("R10 one master bit", {31'd0, irq_out}, 32'h0);
        wr_reg(W_MASTER, 32'h2);
        check("R10 other master bit", {31'd0, irq_out}, 32'h0);
        wr_reg(W_MASTER, 32'h3);
        rd_check("R10 master reads back", W_MASTER, 32'h3);
        check("R10 both bits", {31'd0, irq_out}, 32'h1);
        wr_reg(W_STATUS, 32'hFFFF_FFFF);
        rd_check("R11 status write ignored", W_STATUS, 32'h0000_1220);
        wr_reg(W_VEC, 32'h0);
        rd_check("R11 vector write ignored", W_VEC, 32'd5);
        rd_check("R11 ack word reads zero", W_ACK, 32'h0);
        wr_reg(W_ENAB, 32'h0);
        check("R10 no pending no irq", {31'd0, irq_out}, 32'h0);
        irq_in = '0;
        wr_reg(W_ACK, 32'hFFFF_FFFF);
        rd_check("R4 ack all ones", W_STATUS, 32'h0);
        rd_check("R9 empty after ack", W_VEC, 32'hFFFF_FFFF);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_level();
        t_edge();
        t_pending_vector();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule